// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recently used page mappings and turns a 32-bit virtual address into a physical address. Pages are 4 KB. The 12-bit page offset passes through unchanged. The upper 20 bits, the virtual page number, are compared against every stored entry in the same cycle. Each entry stores a page number, a frame number, two permission bits and two usage flags. The usage flags record whether the entry has been referenced and whether it has been written through.

A requester presents an address together with a store flag. The block accepts the request when `req_ready` is high. One clock edge after acceptance it reports one of three outcomes:

- a translated address, with the entry's usage flags;
- a protection fault;
- a miss.

On a miss, the block holds the request and keeps `miss` high until an external agent installs a mapping through the refill port. The block then repeats the lookup. The refill port can also be used at any other time. A one-cycle invalidate input empties the whole buffer.

Top module: `xlat_cache`

## Requirements
- R1: A completed translation drives `rsp_paddr` with the entry's frame number in bits 31:12 and the request's address bits 11:0 in bits 11:0.
- R2: A request accepted on a clock edge resolves on the next clock edge. For a successful hit, `rsp_valid` is a registered pulse lasting exactly one cycle.
- R3: `rsp_ref` and `rsp_dirty` report the entry's referenced and written flags as they stood before the current access. A permitted hit sets the referenced flag. A permitted store hit also sets the written flag.
- R4: `fill_perm` bit 0 grants loads and bit 1 grants stores. A hit that lacks the needed grant pulses `rsp_fault` instead of `rsp_valid`, and the entry's flags stay unchanged.
- R5: A lookup that finds no entry raises `miss` on the edge that resolves it. `miss` stays high and `req_ready` stays low until a refill is accepted. The lookup then repeats and resolves on the following edge.
- R6: A refill whose page number is already stored overwrites that entry, so no page is ever held twice. Every refill clears the target entry's referenced and written flags.
- R7: A refill for a new page goes to the lowest-numbered empty entry. If every entry is full, it goes to the entry named by a replacement pointer. The pointer is 0 after reset and advances by one, wrapping at 16, each time it is used.
- R8: `flush` empties every entry on the edge where it is high. It takes precedence over a refill in the same cycle, and a lookup resolving in that cycle counts as a miss.
- R9: After reset, `req_ready` is 1, `miss`, `rsp_valid` and `rsp_fault` are 0, and the buffer is empty.
- R10: At most one entry matches any page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load access |
| rsp_valid | output | 1 | One-cycle pulse: translation done |
| rsp_fault | output | 1 | One-cycle pulse: access not permitted |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_ref | output | 1 | Entry's referenced flag before this access |
| rsp_dirty | output | 1 | Entry's written flag before this access |
| miss | output | 1 | Held request has no matching entry |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_vpn | input | 20 | Page number of the mapping |
| fill_pfn | input | 20 | Frame number of the mapping |
| fill_perm | input | 2 | Grants: bit 0 load, bit 1 store |
| flush | input | 1 | Empty the whole buffer |

## Verification
A corrupted page tag or valid flag shows up as a wrong frame number or as a spurious or missing `miss`, on the edge after the next request is accepted. A stuck usage flag is seen through `rsp_ref` or `rsp_dirty` on the second access to the same page. A wrong replacement pointer is seen only when a full buffer receives a refill. The bench therefore fills all sixteen entries and checks which earlier page has been evicted, one refill at a time.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2
  } xlat_state_e;

  localparam int PERM_W  = 2;
  localparam int PERM_LD = 0;
  localparam int PERM_ST = 1;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [VPN_W-1:0]   look_vpn,
  input  logic [VPN_W-1:0]   fill_vpn,
  output logic [ENTRIES-1:0] valid_o,
  output logic [ENTRIES-1:0] look_hit,
  output logic [ENTRIES-1:0] fill_hit
);
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  // Tags and valid flags sit in flops so that every entry can be compared at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= wr_vpn;
        end
      end
    end
  end

  // Two comparators per entry: one for the held request, one for the refill port.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign look_hit[g] = valid_q[g] && (tag_q[g] == look_vpn);
    assign fill_hit[g] = valid_q[g] && (tag_q[g] == fill_vpn);
  end

  assign valid_o = valid_q;

  assert_single_match_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(look_hit));
  assert_single_fill_match_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fill_hit));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_o == '0));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  // Lowest-numbered empty entry.
  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!free_found && !valid_i[i]) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  assign victim_idx = free_found ? free_idx : ptr_q;

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (advance) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assert_victim_free_R7: assert property (@(posedge clk) disable iff (rst)
    !(&valid_i) |-> !valid_i[victim_idx]);
endmodule

// File: rtl/xlat_payload.sv
module xlat_payload #(
  parameter int ENTRIES = 16,
  parameter int PFN_W   = 20,
  parameter int PERM_W  = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              touch_en,
  input  logic [IDX_W-1:0]  touch_idx,
  input  logic              touch_store,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PFN_W-1:0]  rd_pfn,
  output logic [PERM_W-1:0] rd_perm,
  output logic              rd_ref,
  output logic              rd_dirty
);
  // Frame and grant storage: one write port, no reset, read by index (distributed RAM).
  logic [PFN_W-1:0]   pfn_mem  [ENTRIES];
  logic [PERM_W-1:0]  perm_mem [ENTRIES];
  logic [ENTRIES-1:0] ref_q;
  logic [ENTRIES-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      pfn_mem[wr_idx]  <= wr_pfn;
      perm_mem[wr_idx] <= wr_perm;
    end
  end

  // Usage flags: a refill to the same entry wins over a touch.
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_en && wr_idx == IDX_W'(i)) begin
          ref_q[i]   <= 1'b0;
          dirty_q[i] <= 1'b0;
        end else if (touch_en && touch_idx == IDX_W'(i)) begin
          ref_q[i] <= 1'b1;
          if (touch_store) dirty_q[i] <= 1'b1;
        end
      end
    end
  end

  assign rd_pfn   = pfn_mem[rd_idx];
  assign rd_perm  = perm_mem[rd_idx];
  assign rd_ref   = ref_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];

  assert_fill_clears_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!ref_q[$past(wr_idx)] && !dirty_q[$past(wr_idx)]));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 16,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PFN_W    = PA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [VA_W-1:0]            req_vaddr,
  input  logic                       req_store,
  output logic                       rsp_valid,
  output logic                       rsp_fault,
  output logic [PA_W-1:0]            rsp_paddr,
  output logic                       rsp_ref,
  output logic                       rsp_dirty,
  output logic                       miss,
  input  logic                       fill_valid,
  input  logic [VPN_W-1:0]           fill_vpn,
  input  logic [PFN_W-1:0]           fill_pfn,
  input  logic [xlat_pkg::PERM_W-1:0] fill_perm,
  input  logic                       flush
);
  import xlat_pkg::*;

  xlat_state_e          state_q;
  logic [VPN_W-1:0]     vpn_q;
  logic [PAGE_BITS-1:0] off_q;
  logic                 store_q;

  logic [ENTRIES-1:0]   valid_vec, look_hit, fill_hit;
  logic [IDX_W-1:0]     hit_idx, dup_idx, victim_idx, wr_idx;
  logic                 hit_any, fill_dup, fill_en, advance;
  logic                 allowed, touch_en;
  logic [PFN_W-1:0]     rd_pfn;
  logic [PERM_W-1:0]    rd_perm;
  logic                 rd_ref, rd_dirty;

  // One-hot to index, for the held request and for the refill port.
  always_comb begin
    hit_idx = '0;
    dup_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_hit[i]) hit_idx = hit_idx | IDX_W'(i);
      if (fill_hit[i]) dup_idx = dup_idx | IDX_W'(i);
    end
  end

  assign hit_any  = (|look_hit) && !flush;
  assign fill_dup = |fill_hit;
  assign fill_en  = fill_valid && !flush;
  assign wr_idx   = fill_dup ? dup_idx : victim_idx;
  assign advance  = fill_en && !fill_dup && (&valid_vec);
  assign allowed  = store_q ? rd_perm[PERM_ST] : rd_perm[PERM_LD];
  assign touch_en = (state_q == ST_LOOK) && hit_any && allowed;

  xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .wr_en    (fill_en),
    .wr_idx   (wr_idx),
    .wr_vpn   (fill_vpn),
    .look_vpn (vpn_q),
    .fill_vpn (fill_vpn),
    .valid_o  (valid_vec),
    .look_hit (look_hit),
    .fill_hit (fill_hit)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_vec),
    .advance    (advance),
    .victim_idx (victim_idx)
  );

  xlat_payload #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .PERM_W(PERM_W)) u_payload (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (fill_en),
    .wr_idx      (wr_idx),
    .wr_pfn      (fill_pfn),
    .wr_perm     (fill_perm),
    .touch_en    (touch_en),
    .touch_idx   (hit_idx),
    .touch_store (store_q),
    .rd_idx      (hit_idx),
    .rd_pfn      (rd_pfn),
    .rd_perm     (rd_perm),
    .rd_ref      (rd_ref),
    .rd_dirty    (rd_dirty)
  );

  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      vpn_q     <= '0;
      off_q     <= '0;
      store_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_ref   <= 1'b0;
      rsp_dirty <= 1'b0;
      miss      <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          vpn_q   <= req_vaddr[VA_W-1:PAGE_BITS];
          off_q   <= req_vaddr[PAGE_BITS-1:0];
          store_q <= req_store;
          state_q <= ST_LOOK;
        end
        ST_LOOK: if (hit_any) begin
          state_q <= ST_IDLE;
          if (allowed) begin
            rsp_valid <= 1'b1;
            rsp_paddr <= {rd_pfn, off_q};
            rsp_ref   <= rd_ref;
            rsp_dirty <= rd_dirty;
          end else begin
            rsp_fault <= 1'b1;
          end
        end else begin
          miss    <= 1'b1;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (fill_en) begin
          miss    <= 1'b0;
          state_q <= ST_LOOK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_fault));
  assert_hit_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  assert_miss_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    miss |-> !req_ready);
  assert_miss_held_R5: assert property (@(posedge clk) disable iff (rst)
    (miss && !fill_en) |=> miss);
endmodule

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic        rsp_valid, rsp_fault, rsp_ref, rsp_dirty, miss;
  logic [31:0] rsp_paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [1:0]  fill_perm = '0;
  logic        flush = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  xlat_cache u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_ref(rsp_ref),
    .rsp_dirty(rsp_dirty), .miss(miss), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_perm(fill_perm), .flush(flush)
  );

  typedef struct packed {
    logic        st;
    logic [31:0] va;
    logic        flt;
    logic [31:0] pa;
    logic        rf;
    logic        dt;
  } vec_t;

  // Mappings: 0x00010->0x00A10 load+store, 0x00020->0x00B20 load only,
  // 0x12345->0x54321 store only, 0xABCDE->0x0F00D load+store (one hit already).
  localparam vec_t VECS [9] = '{
    '{1'b0, 32'h00010ABC, 1'b0, 32'h00A10ABC, 1'b0, 1'b0},
    '{1'b1, 32'h00010FFF, 1'b0, 32'h00A10FFF, 1'b1, 1'b0},
    '{1'b0, 32'h00010000, 1'b0, 32'h00A10000, 1'b1, 1'b1},
    '{1'b1, 32'h00020004, 1'b1, 32'h00000000, 1'b0, 1'b0},
    '{1'b0, 32'h00020004, 1'b0, 32'h00B20004, 1'b0, 1'b0},
    '{1'b0, 32'h12345678, 1'b1, 32'h00000000, 1'b0, 1'b0},
    '{1'b1, 32'h12345678, 1'b0, 32'h54321678, 1'b0, 1'b0},
    '{1'b1, 32'h12345001, 1'b0, 32'h54321001, 1'b1, 1'b1},
    '{1'b0, 32'hABCDE123, 1'b0, 32'h0F00D123, 1'b1, 1'b0}
  };

  task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  // Request is accepted on the edge after the drive; the outcome is visible after the next edge.
  task automatic send(input logic [31:0] va, input logic st);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [1:0] perm);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 req_ready after reset", 32'(req_ready), 32'd1);
    chk("R9 miss after reset", 32'(miss), 32'd0);
    chk("R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R9 rsp_fault after reset", 32'(rsp_fault), 32'd0);

    // R5, R9: empty buffer misses, request held until refill
    send(32'hABCDE123, 1'b0);
    chk("R5 miss raised", 32'(miss), 32'd1);
    chk("R5 req_ready low on miss", 32'(req_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk("R5 miss held", 32'(miss), 32'd1);
    fill(20'hABCDE, 20'h0F00D, 2'b11);
    chk("R5 miss cleared by refill", 32'(miss), 32'd0);
    @(negedge clk);
    chk("R5 retried lookup completes", 32'(rsp_valid), 32'd1);
    chk("R1 retried lookup address", rsp_paddr, 32'h0F00D123);

    fill(20'h00010, 20'h00A10, 2'b11);
    fill(20'h00020, 20'h00B20, 2'b01);
    fill(20'h12345, 20'h54321, 2'b10);

    // Table walk: R1 address, R3 flags, R4 grants
    for (int i = 0; i < 9; i++) begin
      send(VECS[i].va, VECS[i].st);
      if (VECS[i].flt) begin
        chk($sformatf("R4 vec%0d fault", i), 32'(rsp_fault), 32'd1);
        chk($sformatf("R4 vec%0d no valid", i), 32'(rsp_valid), 32'd0);
      end else begin
        chk($sformatf("R2 vec%0d valid", i), 32'(rsp_valid), 32'd1);
        chk($sformatf("R1 vec%0d paddr", i), rsp_paddr, VECS[i].pa);
        chk($sformatf("R3 vec%0d ref", i), 32'(rsp_ref), 32'(VECS[i].rf));
        chk($sformatf("R3 vec%0d dirty", i), 32'(rsp_dirty), 32'(VECS[i].dt));
        @(negedge clk);
        chk($sformatf("R2 vec%0d single pulse", i), 32'(rsp_valid), 32'd0);
      end
    end

    // R6: refill of a stored page overwrites it and clears its flags
    fill(20'h00010, 20'h00C10, 2'b11);
    send(32'h00010123, 1'b0);
    chk("R6 overwrite paddr", rsp_paddr, 32'h00C10123);
    chk("R6 ref cleared", 32'(rsp_ref), 32'd0);
    chk("R6 dirty cleared", 32'(rsp_dirty), 32'd0);

    // R8: flush empties the buffer
    pulse_flush();
    send(32'h00010123, 1'b0);
    chk("R8 miss after flush", 32'(miss), 32'd1);
    fill(20'h00010, 20'h00C10, 2'b11);
    @(negedge clk);
    chk("R8 refill after flush hits", rsp_paddr, 32'h00C10123);

    // R8: flush beats a refill in the same cycle
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h00777; fill_pfn = 20'h00888; fill_perm = 2'b11;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    send(32'h00777000, 1'b0);
    chk("R8 refill dropped under flush", 32'(miss), 32'd1);
    fill(20'h00777, 20'h00888, 2'b11);
    @(negedge clk);
    chk("R8 later refill completes", rsp_paddr, 32'h00888000);

    // R7: fill all 16 entries, then replacement follows the pointer 0,1,2...
    pulse_flush();
    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 2'b11);
    fill(20'h00300, 20'h00400, 2'b11);
    send(32'h00100000, 1'b0);
    chk("R7 entry 0 replaced first", 32'(miss), 32'd1);
    fill(20'h00100, 20'h00500, 2'b11);
    @(negedge clk);
    chk("R7 refill completes", rsp_paddr, 32'h00500000);
    send(32'h00101000, 1'b0);
    chk("R7 entry 1 replaced next", 32'(miss), 32'd1);
    fill(20'h00101, 20'h00600, 2'b11);
    @(negedge clk);
    chk("R7 second refill completes", rsp_paddr, 32'h00600000);
    send(32'h00103ABC, 1'b0);
    chk("R7 untouched entry kept", rsp_paddr, 32'h00203ABC);
    send(32'h00300000, 1'b0);
    chk("R7 replacing page present", rsp_paddr, 32'h00400000);
    send(32'h00102000, 1'b0);
    chk("R7 entry 2 replaced third", 32'(miss), 32'd1);
    fill(20'h00102, 20'h00700, 2'b11);
    @(negedge clk);
    chk("R7 third refill completes", rsp_paddr, 32'h00700000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule